// File: doc/BRIEF.md
# Four-Lane Addressable-LED Byte Serializer

This block turns a stream of byte-wide transfers into four parallel one-wire LED data lines. Each accepted transfer carries a lane-enable mask and one byte per lane. Each enabled lane sends its byte most significant bit first, using pulse-width coding: every bit starts with a high pulse whose length gives the bit's value, and the line then stays low for the rest of the bit period. A disabled lane holds its line low for the whole byte slot. A run of such quiet slots gives the latch/reset gap that addressable LEDs need between frames.

All four lanes share one slot timer, so their edges line up on the same clock cycles. At a 125 MHz clock every byte slot lasts exactly 1250 cycles: eight 156-cycle bits followed by two extra low cycles. A four-entry queue sits between the feeder and the slot timer. A transfer is accepted on any cycle where `in_valid` and `in_ready` are both high. `in_ready` falls only when the queue holds four entries, and the feeder must then hold its transfer stable until `in_ready` returns. If a slot ends while the queue is empty, the block raises a sticky underrun flag. Software clears that flag with a one-cycle clear pulse.

Top module: `led4_serializer`

## Requirements
- R1: A transfer's `in_mask` bit k enables lane k. The lane's byte is `in_bytes[8k+7:8k]`, and it goes out on `lane_out[k]` most significant bit first.
- R2: A zero bit is high for 47 cycles. Each bit period is 156 cycles, measured from one rising edge to the next within a byte.
- R3: A one bit is high for 109 cycles, and the line is never high later than cycle 109 of a bit period.
- R4: A byte slot lasts 1250 cycles: the eight bits plus two trailing low cycles. Back to back, the last bit's rising edge and the next slot's first rising edge are 158 cycles apart. Each quiet slot in between adds 1250 cycles to that gap.
- R5: A lane whose mask bit is 0 stays low for the whole slot, whatever value its byte holds.
- R6: Lanes that are enabled in the same slot rise on the same clock cycle.
- R7: The queue holds up to four transfers. `in_ready` is low exactly when four transfers wait in the queue.
- R8: `stall` is set when a slot ends and the queue is empty. It stays set until a `stall_clr` pulse arrives, and a set in the same cycle as a clear wins.
- R9: While no slot is running, every lane is low. When data arrives, transmission resumes with a complete byte slot.
- R10: After reset, all lanes are low, `stall` is 0 and `in_ready` is 1. Idling with no data ever sent does not set `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (125 MHz for nominal timing) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Queue can take a transfer |
| in_mask | input | 4 | Per-lane enable, bit k for lane k |
| in_bytes | input | 32 | Lane k byte in bits 8k+7..8k |
| stall_clr | input | 1 | Write-one-to-clear pulse for `stall` |
| stall | output | 1 | Sticky queue-underrun flag |
| lane_out | output | 4 | Serial LED data lines |

## Verification
The first pattern drives all lanes enabled with mixed bytes such as 0x80, 0x01, 0xFF and 0x00. A wrong bit order, a wrong pulse width, or a misaligned lane shows up there as a pulse-length or rising-edge mismatch. The second pattern mixes masks and puts nonzero bytes on disabled lanes, with an all-disabled slot in the middle. This separates a lane that really stays quiet from one that leaks data, and the 1250-cycle gap across skipped slots exposes slot-length errors. The third pattern fills the queue while a slot is running, which checks that `in_ready` falls at exactly four entries. It also shows that a run started while `stall` is still set is transmitted whole and leaves the flag set.

// File: rtl/led4_pkg.sv
package led4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BITS = 2'd1,
    ST_TAIL = 2'd2
  } slot_st_e;
endpackage

// File: rtl/led4_fifo.sv
module led4_fifo #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (count == CW'(DEPTH)) || $past(pop));
endmodule

// File: rtl/led4_slot_timer.sv
module led4_slot_timer
  import led4_pkg::*;
#(
  parameter int unsigned BIT_CYC = 156,
  parameter int unsigned TAIL    = 2,
  parameter int unsigned BITS    = 8,
  localparam int unsigned CYW    = $clog2(BIT_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           have_data,
  output logic           load,
  output logic           slot_end,
  output logic           bits_active,
  output logic           bit_last,
  output logic [CYW-1:0] cyc
);
  localparam int unsigned BW   = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int unsigned SLOT = BITS * BIT_CYC + TAIL;

  slot_st_e      st;
  logic [BW-1:0] bit_idx;

  assign bits_active = (st == ST_BITS);
  assign bit_last    = bits_active && (cyc == CYW'(BIT_CYC - 1));
  assign slot_end    = (st == ST_TAIL) && (cyc == CYW'(TAIL - 1));
  assign load        = have_data && ((st == ST_IDLE) || slot_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_idx <= '0;
      cyc     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (have_data) begin
            st      <= ST_BITS;
            bit_idx <= '0;
            cyc     <= '0;
          end
        end
        ST_BITS: begin
          if (bit_last) begin
            cyc <= '0;
            if (bit_idx == BW'(BITS - 1)) st <= ST_TAIL;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        ST_TAIL: begin
          if (slot_end) begin
            cyc     <= '0;
            bit_idx <= '0;
            st      <= have_data ? ST_BITS : ST_IDLE;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checker-side slot length counter, restarted on every load.
  int unsigned sc_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              sc_q <= 0;
    else if (load)           sc_q <= 0;
    else if (sc_q < SLOT)    sc_q <= sc_q + 1;
  end

  // R4
  slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (sc_q == SLOT - 1));
endmodule

// File: rtl/led4_lane.sv
module led4_lane #(
  parameter int unsigned HI0  = 47,
  parameter int unsigned HI1  = 109,
  parameter int unsigned BITS = 8,
  parameter int unsigned CYW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            en_in,
  input  logic [BITS-1:0] byte_in,
  input  logic            bits_active,
  input  logic            bit_last,
  input  logic [CYW-1:0]  cyc,
  output logic            line
);
  logic            en_q;
  logic [BITS-1:0] sh_q;
  logic            hi;

  assign hi = bits_active && en_q &&
              (cyc < (sh_q[BITS-1] ? CYW'(HI1) : CYW'(HI0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      sh_q <= '0;
      line <= 1'b0;
    end else begin
      line <= hi;
      if (load) begin
        en_q <= en_in;
        sh_q <= byte_in;
      end else if (bit_last) begin
        sh_q <= sh_q << 1;
      end
    end
  end

  // R5
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_active && !en_q) |=> !line);
  // R6
  rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line) |-> (cyc == CYW'(1)));
  // R3
  hi_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line |-> (cyc >= CYW'(1) && cyc <= CYW'(HI1)));
endmodule

// File: rtl/led4_serializer.sv
module led4_serializer #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned HI0     = 47,
  parameter int unsigned HI1     = 109,
  parameter int unsigned BIT_CYC = 156,
  parameter int unsigned TAIL    = 2,
  localparam int unsigned BITS   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES-1:0]      in_mask,
  input  logic [LANES*BITS-1:0] in_bytes,
  input  logic                  stall_clr,
  output logic                  stall,
  output logic [LANES-1:0]      lane_out
);
  localparam int unsigned DW  = LANES * BITS;
  localparam int unsigned FW  = LANES + DW;
  localparam int unsigned CYW = $clog2(BIT_CYC);

  logic [FW-1:0]  q_data;
  logic           q_valid;
  logic           load, slot_end, bits_active, bit_last;
  logic [CYW-1:0] cyc;

  led4_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({in_mask, in_bytes}),
    .out_valid (q_valid),
    .out_ready (load),
    .out_data  (q_data)
  );

  led4_slot_timer #(.BIT_CYC(BIT_CYC), .TAIL(TAIL), .BITS(BITS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .have_data   (q_valid),
    .load        (load),
    .slot_end    (slot_end),
    .bits_active (bits_active),
    .bit_last    (bit_last),
    .cyc         (cyc)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    led4_lane #(.HI0(HI0), .HI1(HI1), .BITS(BITS), .CYW(CYW)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .en_in       (q_data[DW + k]),
      .byte_in     (q_data[k*BITS +: BITS]),
      .bits_active (bits_active),
      .bit_last    (bit_last),
      .cyc         (cyc),
      .line        (lane_out[k])
    );
  end

  logic stall_set;
  assign stall_set = slot_end && !q_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)         stall <= 1'b0;
    else if (stall_set) stall <= 1'b1;
    else if (stall_clr) stall <= 1'b0;
  end

  // R8
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !q_valid) |=> stall);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !stall_clr) |=> stall);
  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bits_active |=> (lane_out == '0));
endmodule

// File: tb/test_led4_serializer.sv
module test_led4_serializer;
  localparam int LANES = 4;
  localparam int SLOT  = 1250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mask = '0;
  logic [31:0] in_bytes = '0;
  logic        stall_clr = 1'b0;
  logic        stall;
  logic [3:0]  lane_out;

  always #2.5 clk = ~clk;

  led4_serializer i_led4_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_bytes(in_bytes), .stall_clr(stall_clr),
    .stall(stall), .lane_out(lane_out)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc_n = 0;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard: per lane, expected rising edges encoded as gap*2 + bit.
  int expq [4][$];
  bit seen [4];
  int skip [4];
  int rises [4];
  int first_rise [4];
  int last_rise [4];
  int hcnt [4];
  bit cur_bit [4];
  logic [3:0] prev = '0;

  task automatic begin_burst();
    for (int k = 0; k < LANES; k++) begin
      seen[k] = 0; skip[k] = 0; rises[k] = 0; first_rise[k] = -1;
    end
  endtask

  task automatic send(input logic [3:0] m, input logic [31:0] b);
    for (int k = 0; k < LANES; k++) begin
      if (m[k]) begin
        for (int j = 7; j >= 0; j--) begin
          int gap;
          if (j != 7) gap = 156;
          else if (seen[k]) gap = 158 + SLOT * skip[k];
          else gap = 0;
          expq[k].push_back(gap * 2 + int'(b[8*k + j]));
        end
        seen[k] = 1;
        skip[k] = 0;
      end else if (seen[k]) begin
        skip[k]++;
      end
    end
    in_mask = m;
    in_bytes = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: decodes each lane's pulses and compares with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_out[k] && !prev[k]) begin
          rises[k]++;
          hcnt[k] = 1;
          if (first_rise[k] < 0) first_rise[k] = cyc_n;
          if (expq[k].size() == 0) begin
            chk(0, "R9 unexpected pulse", k, -1);
          end else begin
            int v;
            v = expq[k].pop_front();
            cur_bit[k] = v[0];
            if ((v >> 1) != 0)
              chk(cyc_n - last_rise[k] == (v >> 1), "R4/R2 rise spacing",
                  cyc_n - last_rise[k], v >> 1);
          end
          last_rise[k] = cyc_n;
        end else if (lane_out[k]) begin
          hcnt[k]++;
        end else if (prev[k]) begin
          if (cur_bit[k]) chk(hcnt[k] == 109, "R3 one-bit width", hcnt[k], 109);
          else            chk(hcnt[k] == 47,  "R2 zero-bit width", hcnt[k], 47);
        end
      end
      prev = lane_out;
    end
  end

  task automatic drain();
    int guard = 0;
    while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size()) != 0
           && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (SLOT + 50) @(negedge clk);
    for (int k = 0; k < LANES; k++)
      chk(expq[k].size() == 0, "R1 all expected bits seen", expq[k].size(), 0);
    chk(lane_out == 4'h0, "R9 lanes low when idle", int'(lane_out), 0);
    chk(stall == 1'b1, "R8 stall set on underrun", int'(stall), 1);
  endtask

  task automatic clear_stall();
    stall_clr = 1'b1;
    @(negedge clk);
    stall_clr = 1'b0;
    chk(stall == 1'b0, "R8 stall cleared by pulse", int'(stall), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(lane_out == 4'h0, "R10 lanes low in reset", int'(lane_out), 0);
    chk(stall == 1'b0, "R10 stall clear in reset", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
    repeat (3000) @(negedge clk);
    chk(stall == 1'b0, "R10 idle is not a stall", int'(stall), 0);
    chk(lane_out == 4'h0, "R10 lanes low while idle", int'(lane_out), 0);

    // Pattern 1: all lanes on, bit-order and width coverage (R1, R2, R3, R6)
    begin_burst();
    send(4'hF, 32'h80_01_FF_00);
    send(4'hF, 32'hA5_5A_0F_F0);
    send(4'hF, 32'h3C_C3_81_7E);
    drain();
    for (int k = 1; k < LANES; k++)
      chk(first_rise[k] == first_rise[0], "R6 lanes rise together",
          first_rise[k], first_rise[0]);
    for (int k = 0; k < LANES; k++)
      chk(rises[k] == 24, "R1 bit count per lane", rises[k], 24);
    clear_stall();

    // Pattern 2: mixed masks, nonzero bytes on disabled lanes (R4, R5)
    begin_burst();
    send(4'b0101, 32'hFF_11_EE_22);
    send(4'b0000, 32'h00_00_00_00);
    send(4'b1010, 32'h96_FF_69_FF);
    send(4'b1111, 32'h12_34_56_78);
    drain();
    chk(rises[0] == 16, "R5 lane0 quiet when disabled", rises[0], 16);
    chk(rises[1] == 16, "R5 lane1 quiet when disabled", rises[1], 16);
    chk(rises[2] == 16, "R5 lane2 quiet when disabled", rises[2], 16);
    chk(rises[3] == 16, "R5 lane3 quiet when disabled", rises[3], 16);
    repeat (500) @(negedge clk);
    chk(stall == 1'b1, "R8 stall is sticky", int'(stall), 1);

    // Pattern 3: resume while stalled, queue fill (R7, R9)
    begin_burst();
    send(4'b0011, 32'h00_00_C0_03);
    send(4'b1100, 32'hE7_18_00_00);
    send(4'b1111, 32'h01_02_04_08);
    send(4'b0110, 32'h00_AA_55_00);
    send(4'b1001, 32'hF0_00_00_0F);
    chk(in_ready == 1'b0, "R7 ready low with four queued", int'(in_ready), 0);
    chk(stall == 1'b1, "R8 stall stays set during resume", int'(stall), 1);
    send(4'hF, 32'hDE_AD_BE_EF);
    drain();
    chk(in_ready == 1'b1, "R7 ready back once drained", int'(in_ready), 1);
    clear_stall();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule